// File: doc/BRIEF.md
# Bit-Field Insert and Extract Unit

This execution unit performs bit-field insert and extract operations on 64-bit general register values. Each operation takes two 5-bit instruction fields, a high-bit field and a low-bit field. The opcode decides how the two fields become a field width and a starting bit position. With this scheme a pair of 5-bit fields can select any field inside a 64-bit word, including fields wider than 32 bits and fields that lie entirely in the upper half.

Insert operations merge the low bits of a source operand into a window of the current destination value. Extract operations shift a window of the source down to bit 0. The word forms produce a 32-bit result that is sign-extended to 64 bits. The result is registered. It appears one cycle after the request strobe, together with a single-cycle valid strobe.

Top module: `bitfield_unit`

## Requirements
- R1: After reset is released, and before any request, valid_o is 0 and result_o is 0.
- R2: valid_o is 1 exactly in the cycle after a cycle with valid_i high. result_o changes only in response to valid_i and otherwise holds its value.
- R3: Doubleword insert (op_i = 1): size = msb-lsb+1. Bits [msb:lsb] of the result are the low size bits of src_i. Every other bit equals dst_i.
- R4: Word insert (op_i = 0): the insert is done on the low 32 bits of dst_i. The 32-bit result is sign-extended from bit 31, and the upper half of dst_i is discarded.
- R5: An insert with msb < lsb leaves the destination unchanged. For the word form, the result is the low word of dst_i sign-extended.
- R6: Doubleword extract (op_i = 3): size = msb+1 and position = lsb. The field is moved to bit 0 and zero-filled above it. Positions beyond bit 63 read as zero.
- R7: Word extract (op_i = 2): size = msb+1 and position = lsb, taken only from the low 32 bits of src_i (bits beyond 31 read as zero). The 32-bit result is sign-extended from bit 31.
- R8: Middle extract (op_i = 4): size = msb+33 and position = lsb. With msb = 31 and lsb = 0 the size is 64, and the result is all of src_i.
- R9: Upper extract (op_i = 5): position = lsb+32 and size = msb+1. Positions beyond bit 63 read as zero.
- R10: The unused opcodes 6 and 7 produce a result of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| op_i | input | 3 | Operation select (0..5, see requirements) |
| src_i | input | 64 | Source operand |
| dst_i | input | 64 | Current destination value, used by insert |
| msb_i | input | 5 | High-bit instruction field |
| lsb_i | input | 5 | Low-bit instruction field |
| result_o | output | 64 | Registered result |
| valid_o | output | 1 | Result strobe, one cycle |

## Verification
The bench targets the width-64 middle extract. A mask generator that computes (1<<size)-1 in 64 bits would overflow there and return zero or a truncated value instead of the whole source. It also targets word results with bit 31 set, where a missing sign extension leaves the upper half zero, and word insert with a dirty upper destination half, where a design that keeps that half would leak it into the result. Reversed insert fields, upper extracts that run past bit 63, and word extracts that would otherwise pull in bits above 31 each expose decoders that wrap sizes or positions. A seeded sweep over every opcode then compares against a bit-by-bit model.

// File: rtl/bf_pkg.sv
package bf_pkg;
  localparam int unsigned XLEN = 64;

  typedef enum logic [2:0] {
    BF_INS_W  = 3'd0,
    BF_INS_D  = 3'd1,
    BF_EXT_W  = 3'd2,
    BF_EXT_D  = 3'd3,
    BF_EXT_DM = 3'd4,
    BF_EXT_DU = 3'd5
  } bf_op_e;
endpackage

// File: rtl/bf_decode.sv
module bf_decode #(
  parameter int unsigned XLEN = bf_pkg::XLEN,
  localparam int unsigned HALF = XLEN / 2,
  localparam int unsigned FW   = $clog2(HALF),
  localparam int unsigned PW   = $clog2(XLEN),
  localparam int unsigned SW   = $clog2(XLEN) + 1
) (
  input  logic [2:0]    op_i,
  input  logic [FW-1:0] msb_i,
  input  logic [FW-1:0] lsb_i,
  output logic [SW-1:0] size_o,
  output logic [PW-1:0] pos_o,
  output logic          is_ins_o,
  output logic          is_word_o,
  output logic          known_o,
  output logic          empty_o
);
  import bf_pkg::*;

  logic [SW-1:0] msb_w, lsb_w;
  assign msb_w = SW'(msb_i);
  assign lsb_w = SW'(lsb_i);

  always_comb begin
    size_o    = msb_w + SW'(1);
    pos_o     = PW'(lsb_i);
    is_ins_o  = 1'b0;
    is_word_o = 1'b0;
    known_o   = 1'b1;
    empty_o   = 1'b0;
    case (op_i)
      BF_INS_W, BF_INS_D: begin
        is_ins_o  = 1'b1;
        is_word_o = (op_i == BF_INS_W);
        empty_o   = (msb_i < lsb_i);
        size_o    = empty_o ? '0 : (msb_w - lsb_w + SW'(1));
      end
      BF_EXT_W:  is_word_o = 1'b1;
      BF_EXT_D:  ;
      BF_EXT_DM: size_o = msb_w + SW'(HALF + 1);
      BF_EXT_DU: pos_o  = PW'(lsb_i) + PW'(HALF);
      default:   known_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/bf_mask_gen.sv
module bf_mask_gen #(
  parameter int unsigned W = bf_pkg::XLEN,
  localparam int unsigned SW = $clog2(W) + 1
) (
  input  logic [SW-1:0] size_i,
  output logic [W-1:0]  mask_o
);
  // per-bit compare: size == W gives all ones without a wide shift
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign mask_o[i] = (SW'(i) < size_i);
  end
endmodule

// File: rtl/bf_datapath.sv
module bf_datapath #(
  parameter int unsigned XLEN = bf_pkg::XLEN,
  localparam int unsigned HALF = XLEN / 2,
  localparam int unsigned PW   = $clog2(XLEN)
) (
  input  logic [XLEN-1:0] src_i,
  input  logic [XLEN-1:0] dst_i,
  input  logic [XLEN-1:0] mask_i,
  input  logic [PW-1:0]   pos_i,
  input  logic            is_ins_i,
  input  logic            is_word_i,
  input  logic            known_i,
  input  logic            empty_i,
  output logic [XLEN-1:0] result_o
);
  logic [XLEN-1:0] ext_src, ext_val, ins_val, raw;

  assign ext_src = is_word_i ? {{HALF{1'b0}}, src_i[HALF-1:0]} : src_i;
  assign ext_val = (ext_src >> pos_i) & mask_i;
  assign ins_val = empty_i ? dst_i
                 : ((dst_i & ~(mask_i << pos_i)) | ((src_i & mask_i) << pos_i));
  assign raw     = is_ins_i ? ins_val : ext_val;

  always_comb begin
    if (!known_i)       result_o = '0;
    else if (is_word_i) result_o = {{HALF{raw[HALF-1]}}, raw[HALF-1:0]};
    else                result_o = raw;
  end
endmodule

// File: rtl/bitfield_unit.sv
module bitfield_unit #(
  parameter int unsigned XLEN = bf_pkg::XLEN,
  localparam int unsigned FW = $clog2(XLEN / 2),
  localparam int unsigned PW = $clog2(XLEN),
  localparam int unsigned SW = $clog2(XLEN) + 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [2:0]      op_i,
  input  logic [XLEN-1:0] src_i,
  input  logic [XLEN-1:0] dst_i,
  input  logic [FW-1:0]   msb_i,
  input  logic [FW-1:0]   lsb_i,
  output logic [XLEN-1:0] result_o,
  output logic            valid_o
);
  import bf_pkg::*;

  logic [SW-1:0]   size;
  logic [PW-1:0]   pos;
  logic            is_ins, is_word, known, empty;
  logic [XLEN-1:0] mask, comb_res;

  bf_decode #(.XLEN(XLEN)) u_dec (
    .op_i(op_i), .msb_i(msb_i), .lsb_i(lsb_i),
    .size_o(size), .pos_o(pos), .is_ins_o(is_ins), .is_word_o(is_word),
    .known_o(known), .empty_o(empty)
  );

  bf_mask_gen #(.W(XLEN)) u_mask (.size_i(size), .mask_o(mask));

  bf_datapath #(.XLEN(XLEN)) u_dp (
    .src_i(src_i), .dst_i(dst_i), .mask_i(mask), .pos_i(pos),
    .is_ins_i(is_ins), .is_word_i(is_word), .known_i(known), .empty_i(empty),
    .result_o(comb_res)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      valid_o  <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) result_o <= comb_res;
    end
  end

  assert_valid_follow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  assert_valid_drop_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o));
  assert_mask_count_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> ($countones(mask) == int'(size)));
  assert_ext_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == BF_EXT_D) |=> ((result_o >> $past(size)) == '0));
  assert_ins_keep_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == BF_INS_D && msb_i >= lsb_i) |=>
      (((result_o ^ $past(dst_i)) & ~($past(mask) << $past(pos))) == '0));
  assert_unknown_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i > 3'd5) |=> (result_o == '0));
endmodule

// File: tb/bitfield_unit_bench.sv
module bitfield_unit_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [2:0]  op_i = '0;
  logic [63:0] src_i = '0, dst_i = '0;
  logic [4:0]  msb_i = '0, lsb_i = '0;
  logic [63:0] result_o;
  logic        valid_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  bitfield_unit u_bitfield_unit (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
    .src_i(src_i), .dst_i(dst_i), .msb_i(msb_i), .lsb_i(lsb_i),
    .result_o(result_o), .valid_o(valid_o)
  );

  function automatic logic [63:0] model(input logic [2:0] op, input logic [63:0] s,
                                        input logic [63:0] d, input int m, input int l);
    logic [63:0] r;
    int sz, ps, lim;
    r = '0;
    case (op)
      3'd0, 3'd1: begin
        for (int i = 0; i < 64; i++)
          r[i] = (m >= l && i >= l && i <= m) ? s[i-l] : d[i];
        if (op == 3'd0) r = {{32{r[31]}}, r[31:0]};
      end
      3'd2, 3'd3, 3'd4, 3'd5: begin
        sz  = (op == 3'd4) ? m + 33 : m + 1;
        ps  = (op == 3'd5) ? l + 32 : l;
        lim = (op == 3'd2) ? 32 : 64;
        for (int i = 0; i < 64; i++)
          if (i < sz && ps + i < lim) r[i] = s[ps+i];
        if (op == 3'd2) r = {{32{r[31]}}, r[31:0]};
      end
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [2:0] op, input logic [63:0] s, input logic [63:0] d,
                        input int m, input int l);
    @(negedge clk_i);
    op_i = op; src_i = s; dst_i = d; msb_i = 5'(m); lsb_i = 5'(l); valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 valid", {63'd0, valid_o}, 64'd0);
    check("R1 result", result_o, 64'd0);
  endtask

  task automatic t_ins_d;
    run_op(3'd1, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 11, 4);
    check("R3 clear window", result_o, 64'hFFFF_FFFF_FFFF_F00F);
    run_op(3'd1, 64'hFFFF_FFFF_FFFF_FFF5, 64'h0, 31, 28);
    check("R3 high window", result_o, 64'h0000_0000_5000_0000);
  endtask

  task automatic t_ins_w;
    run_op(3'd0, 64'h1, 64'h0, 31, 31);
    check("R4 sign extend", result_o, 64'hFFFF_FFFF_8000_0000);
    run_op(3'd0, 64'hA, 64'h1234_5678_0000_0000, 7, 4);
    check("R4 upper dropped", result_o, 64'h0000_0000_0000_00A0);
  endtask

  task automatic t_empty;
    run_op(3'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'hDEAD_BEEF_0123_4567, 3, 8);
    check("R5 ins_d reversed", result_o, 64'hDEAD_BEEF_0123_4567);
    run_op(3'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hDEAD_BEEF_0123_4567, 3, 8);
    check("R5 ins_w reversed", result_o, 64'h0000_0000_0123_4567);
  endtask

  task automatic t_ext_d;
    run_op(3'd3, 64'h0123_4567_89AB_CDEF, 64'h0, 7, 8);
    check("R6 byte", result_o, 64'h0000_0000_0000_00CD);
    run_op(3'd3, 64'hF000_0000_0000_0000, 64'h0, 31, 31);
    check("R6 past top", result_o, 64'h0000_0000_E000_0000);
  endtask

  task automatic t_ext_w;
    run_op(3'd2, 64'hFFFF_FFFF_8000_0001, 64'h0, 31, 0);
    check("R7 full word sext", result_o, 64'hFFFF_FFFF_8000_0001);
    run_op(3'd2, 64'hFFFF_FFFF_8000_0001, 64'h0, 7, 28);
    check("R7 no upper bits", result_o, 64'h0000_0000_0000_0008);
  endtask

  task automatic t_ext_m;
    run_op(3'd4, 64'h8123_4567_89AB_CDEF, 64'h0, 31, 0);
    check("R8 size 64", result_o, 64'h8123_4567_89AB_CDEF);
    run_op(3'd4, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 0, 0);
    check("R8 size 33", result_o, 64'h0000_0001_FFFF_FFFF);
  endtask

  task automatic t_ext_u;
    run_op(3'd5, 64'h0123_4567_89AB_CDEF, 64'h0, 7, 0);
    check("R9 byte 4", result_o, 64'h0000_0000_0000_0067);
    run_op(3'd5, 64'h8000_0000_0000_0000, 64'h0, 31, 31);
    check("R9 past top", result_o, 64'h0000_0000_0000_0001);
  endtask

  task automatic t_unknown;
    run_op(3'd6, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 31, 0);
    check("R10 op6", result_o, 64'h0);
    run_op(3'd3, 64'hFF, 64'h0, 7, 0);
    run_op(3'd7, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 31, 0);
    check("R10 op7", result_o, 64'h0);
  endtask

  task automatic t_strobe;
    run_op(3'd3, 64'h0123_4567_89AB_CDEF, 64'h0, 3, 0);
    check("R2 valid high", {63'd0, valid_o}, 64'd1);
    check("R2 result", result_o, 64'hF);
    @(negedge clk_i);
    src_i = 64'hFFFF_FFFF_FFFF_FFFF;
    @(negedge clk_i);
    check("R2 valid low", {63'd0, valid_o}, 64'd0);
    check("R2 result held", result_o, 64'hF);
  endtask

  task automatic t_sweep;
    logic [63:0] lf = 64'hACE1_2468_1357_9BDF;
    for (int k = 0; k < 300; k++) begin
      logic [63:0] s, d;
      logic [2:0] op;
      int m, l;
      lf = {lf[62:0], lf[63] ^ lf[62] ^ lf[60] ^ lf[59]};
      s  = lf ^ {lf[31:0], lf[63:32]};
      d  = ~{lf[15:0], lf[63:16]};
      op = 3'(k % 6);
      m  = int'(lf[4:0]);
      l  = int'(lf[12:8]);
      run_op(op, s, d, m, l);
      case (op)
        3'd0: check("R4 sweep", result_o, model(op, s, d, m, l));
        3'd1: check("R3 sweep", result_o, model(op, s, d, m, l));
        3'd2: check("R7 sweep", result_o, model(op, s, d, m, l));
        3'd3: check("R6 sweep", result_o, model(op, s, d, m, l));
        3'd4: check("R8 sweep", result_o, model(op, s, d, m, l));
        default: check("R9 sweep", result_o, model(op, s, d, m, l));
      endcase
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_ins_d();
    t_ins_w();
    t_empty();
    t_ext_d();
    t_ext_w();
    t_ext_m();
    t_ext_u();
    t_unknown();
    t_strobe();
    t_sweep();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk_i);
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule